// File: doc/BRIEF.md
# Strap-Selected LED Status Indicator

This block drives a green and a red indicator LED through open-drain, active-low pins. The way each LED behaves depends on two things. The first is a display mode, picked once from an ADC reading of a resistor-divider strap. The second is the operational status of the power stage: standby, power transfer, transfer complete or fault. For each status and each colour, a mode shows the LED off, steadily on, blinking at 1 Hz or blinking at 4 Hz. Both blink rates are derived from the system clock.

Twelve strap levels are decoded. They form two banks of six. Both banks show the same six LED pattern sets. The lower bank marks a low-value current-sense resistor and the upper bank marks a higher-value one. The block reports the bank on a single bit so that the current-limit logic knows which resistor is fitted. The mode is captured from the first strap sample after reset and then held. Three of the six pattern sets are fixed in logic. The other three come from a parameter table and can be changed per instance.

Top module: `led_status_ind`

## Requirements
- R1: Strap decode. The nominal strap levels in mV for modes 1 to 12 are 0, 110, 180, 260, 330, 410, 630, 710, 780, 860, 930 and 1010. The ADC is ADC_W = 12 bits wide with a full scale of FS_MV = 2400 mV. Each decision threshold code is floor(mid_mV * 4096 / 2400), where mid_mV is the midpoint of two adjacent nominal levels. A code equal to or above a threshold selects the upper of the two modes.
- R2: The mode is taken from the first cycle after reset in which `strap_sample` is high. Later samples do not change the mode or the sense bit.
- R3: `sense_hi_ohm` is 0 before the mode is captured. After capture it is 0 for modes 1 to 6 and 1 for modes 7 to 12.
- R4: Both LED pins are active low: 0 means lit. Until the mode is captured, both pins stay at 1 whatever the status.
- R5: `op_status` encoding is 0 = standby, 1 = transfer, 2 = complete, 3 = fault. Modes 1 and 7 behave as follows. Green is on only during transfer. Red is off except in fault, where it blinks at 4 Hz.
- R6: Modes 3 and 9 behave as follows. Green is off in standby, blinks at 1 Hz in transfer, is on at complete and blinks at 4 Hz in fault. Red is always off.
- R7: Modes 5 and 11 behave as follows. Green is on in standby, blinks at 1 Hz in transfer, is on at complete and is off in fault. Red is on in standby, off in transfer and at complete, and blinks at 4 Hz in fault.
- R8: Modes 2/8, 4/10 and 6/12 follow the `ALT_PAT` parameter. The default values are listed here by status: standby, transfer, complete, fault.
  - Modes 2/8: green on/off/off/off; red on/off/off/4 Hz.
  - Modes 4/10: green off/on/off/4 Hz; red always off.
  - Modes 6/12: green off/off/on/off; red off/on/off/4 Hz.
- R9: A new `op_status` value is captured at a clock edge. The LEDs show the pattern for the new status from that edge onward.
- R10: A 1 Hz blink has a period of CLK_HZ cycles and is lit for the first CLK_HZ/2 cycles. A 4 Hz blink has a period of CLK_HZ/4 cycles and is lit for the first half of that period.
- R11: Whenever the captured status changes, both blink phases restart. The edge that captures the new status starts the lit half of the blink.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_code | input | ADC_W | ADC code of the strap voltage |
| strap_sample | input | 1 | Strobe: strap_code is valid this cycle |
| op_status | input | 2 | Operational status code (R5 encoding) |
| led_grn_n | output | 1 | Green LED sink, 0 = lit |
| led_red_n | output | 1 | Red LED sink, 0 = lit |
| sense_hi_ohm | output | 1 | 1 when the strap selects the higher-value sense resistor |

## Verification
The bench decodes codes on both sides of two thresholds. One is the lowest threshold, between mode 1 and mode 2. The other is the threshold between the two banks, where the sense bit changes. An off-by-one comparison would put a code in the wrong mode or flip the sense bit one code early. A second, different strap sample follows the first one; a design that keeps re-latching would switch patterns partway through the run. The bench also returns to a blinking status while the previous blink was in its dark half. A timer that does not restart its phase would then start dark instead of lit. Checking the output on every cycle also catches a wrong blink period or duty cycle.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_XFER    = 2'd1,
    ST_DONE    = 2'd2,
    ST_FAULT   = 2'd3
  } op_state_e;

  typedef enum logic [1:0] {
    BH_OFF  = 2'd0,
    BH_ON   = 2'd1,
    BH_SLOW = 2'd2,
    BH_FAST = 2'd3
  } led_beh_e;

  typedef struct packed {
    led_beh_e grn;
    led_beh_e red;
  } led_pair_t;

  localparam int NUM_MODES = 12;
  localparam int NUM_PATS  = 6;
  localparam int ALT_W     = 3 * 4 * 2 * 2;

  // Nominal strap level of each mode in millivolts.
  function automatic int strap_nom_mv(input int idx);
    case (idx)
      0:  return 0;
      1:  return 110;
      2:  return 180;
      3:  return 260;
      4:  return 330;
      5:  return 410;
      6:  return 630;
      7:  return 710;
      8:  return 780;
      9:  return 860;
      10: return 930;
      default: return 1010;
    endcase
  endfunction

  // Threshold code between mode idx and idx+1: midpoint voltage scaled to ADC code.
  function automatic int strap_thr_code(input int idx, input int adc_w, input int fs_mv);
    longint mid;
    mid = longint'((strap_nom_mv(idx) + strap_nom_mv(idx + 1)) / 2);
    return int'((mid * (longint'(1) << adc_w)) / longint'(fs_mv));
  endfunction

  // Packs one behaviour into the alternative table: p = table row, s = status, c = colour (0 green).
  function automatic logic [ALT_W-1:0] alt_put(input logic [ALT_W-1:0] t, input int p,
                                               input int s, input int c, input led_beh_e b);
    logic [ALT_W-1:0] r;
    r = t;
    r[((p * 4 + s) * 2 + c) * 2 +: 2] = b;
    return r;
  endfunction

  function automatic logic [ALT_W-1:0] alt_pat_default();
    logic [ALT_W-1:0] t;
    t = '0;
    // row 0: modes 2 / 8
    t = alt_put(t, 0, 0, 0, BH_ON);
    t = alt_put(t, 0, 0, 1, BH_ON);
    t = alt_put(t, 0, 3, 1, BH_FAST);
    // row 1: modes 4 / 10
    t = alt_put(t, 1, 1, 0, BH_ON);
    t = alt_put(t, 1, 3, 0, BH_FAST);
    // row 2: modes 6 / 12
    t = alt_put(t, 2, 2, 0, BH_ON);
    t = alt_put(t, 2, 1, 1, BH_ON);
    t = alt_put(t, 2, 3, 1, BH_FAST);
    return t;
  endfunction

  // Fixed pattern sets: pat 0 (modes 1/7), pat 2 (modes 3/9), pat 4 (modes 5/11).
  function automatic led_pair_t fixed_pat(input logic [3:0] pat, input op_state_e st);
    led_pair_t r;
    r = '{grn: BH_OFF, red: BH_OFF};
    case (pat)
      4'd0: begin
        if (st == ST_XFER)  r.grn = BH_ON;
        if (st == ST_FAULT) r.red = BH_FAST;
      end
      4'd2: begin
        case (st)
          ST_XFER:  r.grn = BH_SLOW;
          ST_DONE:  r.grn = BH_ON;
          ST_FAULT: r.grn = BH_FAST;
          default:  r.grn = BH_OFF;
        endcase
      end
      default: begin
        case (st)
          ST_STANDBY: begin r.grn = BH_ON;   r.red = BH_ON;   end
          ST_XFER:    begin r.grn = BH_SLOW; r.red = BH_OFF;  end
          ST_DONE:    begin r.grn = BH_ON;   r.red = BH_OFF;  end
          default:    begin r.grn = BH_OFF;  r.red = BH_FAST; end
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic beh_lit(input led_beh_e b, input logic slow_on, input logic fast_on);
    case (b)
      BH_ON:   return 1'b1;
      BH_SLOW: return slow_on;
      BH_FAST: return fast_on;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/led_strap_decode.sv
module led_strap_decode
  import led_ind_pkg::*;
#(
  parameter int ADC_W = 12,
  parameter int FS_MV = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] strap_code,
  input  logic             strap_sample,
  output logic [3:0]       mode_idx,
  output logic             mode_latched,
  output logic             sense_hi
);
  localparam int NUM_THR = NUM_MODES - 1;
  localparam int BANK    = NUM_PATS;

  logic [NUM_THR-1:0] above;
  logic [3:0]         mode_next;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    localparam int THR = strap_thr_code(i, ADC_W, FS_MV);
    assign above[i] = (int'(strap_code) >= THR);
  end

  // thresholds are monotonic, so the count of passed thresholds is the mode index
  assign mode_next = 4'($countones(above));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_idx     <= '0;
      mode_latched <= 1'b0;
      sense_hi     <= 1'b0;
    end else if (strap_sample && !mode_latched) begin
      mode_idx     <= mode_next;
      mode_latched <= 1'b1;
      sense_hi     <= (int'(mode_next) >= BANK);
    end
  end
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer
  import led_ind_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] status_in,
  output op_state_e state_q,
  output logic      state_change,
  output logic      slow_lit,
  output logic      fast_lit
);
  localparam int SLOW_P = CLK_HZ;
  localparam int FAST_P = CLK_HZ / 4;
  localparam int SW     = $clog2(SLOW_P);
  localparam int FW     = $clog2(FAST_P);

  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] fast_cnt;

  assign state_change = (status_in != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_STANDBY;
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      state_q <= op_state_e'(status_in);
      if (state_change) begin
        slow_cnt <= '0;
        fast_cnt <= '0;
      end else begin
        slow_cnt <= (int'(slow_cnt) == SLOW_P - 1) ? '0 : slow_cnt + 1'b1;
        fast_cnt <= (int'(fast_cnt) == FAST_P - 1) ? '0 : fast_cnt + 1'b1;
      end
    end
  end

  assign slow_lit = (int'(slow_cnt) < SLOW_P / 2);
  assign fast_lit = (int'(fast_cnt) < FAST_P / 2);
endmodule

// File: rtl/led_pattern_map.sv
module led_pattern_map
  import led_ind_pkg::*;
#(
  parameter logic [ALT_W-1:0] ALT_PAT = alt_pat_default()
) (
  input  logic [3:0] mode_idx,
  input  logic       mode_latched,
  input  op_state_e  state,
  input  logic       slow_lit,
  input  logic       fast_lit,
  output logic       grn_n,
  output logic       red_n
);
  logic [3:0] pat;
  led_pair_t  pair;
  int         base;

  always_comb begin
    pat  = (int'(mode_idx) >= NUM_PATS) ? 4'(mode_idx - 4'(NUM_PATS)) : mode_idx;
    base = ((int'(pat[3:1]) * 4 + int'(state)) * 2) * 2;
    if (!pat[0]) begin
      pair = fixed_pat(pat, state);
    end else begin
      pair.grn = led_beh_e'(ALT_PAT[base +: 2]);
      pair.red = led_beh_e'(ALT_PAT[base + 2 +: 2]);
    end
    grn_n = !(mode_latched && beh_lit(pair.grn, slow_lit, fast_lit));
    red_n = !(mode_latched && beh_lit(pair.red, slow_lit, fast_lit));
  end
endmodule

// File: rtl/led_status_ind.sv
module led_status_ind
  import led_ind_pkg::*;
#(
  parameter int               CLK_HZ  = 50_000_000,
  parameter int               ADC_W   = 12,
  parameter int               FS_MV   = 2400,
  parameter logic [ALT_W-1:0] ALT_PAT = alt_pat_default()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] strap_code,
  input  logic             strap_sample,
  input  logic [1:0]       op_status,
  output logic             led_grn_n,
  output logic             led_red_n,
  output logic             sense_hi_ohm
);
  logic [3:0] mode_idx;
  logic       mode_latched;
  op_state_e  cur_state;
  logic       state_change;
  logic       slow_lit;
  logic       fast_lit;

  led_strap_decode #(.ADC_W(ADC_W), .FS_MV(FS_MV)) u_strap (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_code   (strap_code),
    .strap_sample (strap_sample),
    .mode_idx     (mode_idx),
    .mode_latched (mode_latched),
    .sense_hi     (sense_hi_ohm)
  );

  led_blink_timer #(.CLK_HZ(CLK_HZ)) u_blink (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_in    (op_status),
    .state_q      (cur_state),
    .state_change (state_change),
    .slow_lit     (slow_lit),
    .fast_lit     (fast_lit)
  );

  led_pattern_map #(.ALT_PAT(ALT_PAT)) u_map (
    .mode_idx     (mode_idx),
    .mode_latched (mode_latched),
    .state        (cur_state),
    .slow_lit     (slow_lit),
    .fast_lit     (fast_lit),
    .grn_n        (led_grn_n),
    .red_n        (led_red_n)
  );
endmodule

// File: rtl/led_status_ind_chk.sv
module led_status_ind_chk
  import led_ind_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       led_grn_n,
  input logic       led_red_n,
  input logic       sense_hi_ohm,
  input logic       mode_latched,
  input logic [3:0] mode_idx,
  input op_state_e  cur_state,
  input logic       state_change,
  input logic       slow_lit,
  input logic       fast_lit
);
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mode_latched |=> mode_latched && $stable(mode_idx));

  a_r3_sense_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mode_latched |=> $stable(sense_hi_ohm));

  a_r3_sense_low_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_latched |-> !sense_hi_ohm);

  a_r4_dark_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_latched |-> led_grn_n && led_red_n);

  a_r11_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    state_change |=> slow_lit && fast_lit);

  a_r5_mode1_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_latched && mode_idx == 4'd0 && cur_state == ST_FAULT)
      |-> led_grn_n && (led_red_n == !fast_lit));

  a_r6_mode3_red_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_latched && (mode_idx == 4'd2 || mode_idx == 4'd8)) |-> led_red_n);
endmodule

bind led_status_ind led_status_ind_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .led_grn_n    (led_grn_n),
  .led_red_n    (led_red_n),
  .sense_hi_ohm (sense_hi_ohm),
  .mode_latched (mode_latched),
  .mode_idx     (mode_idx),
  .cur_state    (cur_state),
  .state_change (state_change),
  .slow_lit     (slow_lit),
  .fast_lit     (fast_lit)
);

// File: tb/led_status_ind_tb.sv
`timescale 1ns/1ps
module led_status_ind_tb;
  localparam int CLK_HZ = 64;
  localparam int ADC_W  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ADC_W-1:0] strap_code = '0;
  logic             strap_sample = 1'b0;
  logic [1:0]       op_status = 2'd0;
  logic             led_grn_n, led_red_n, sense_hi_ohm;

  always #10 clk = ~clk;

  led_status_ind #(.CLK_HZ(CLK_HZ), .ADC_W(ADC_W), .FS_MV(2400)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .strap_sample(strap_sample),
    .op_status(op_status), .led_grn_n(led_grn_n), .led_red_n(led_red_n),
    .sense_hi_ohm(sense_hi_ohm)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: expected {grn_n, red_n, sense} for a given cycle
  int         q_when[$];
  logic [2:0] q_val[$];
  string      q_tag[$];

  // bench model state
  int b_mode = 0;
  bit b_lat  = 0;
  int b_st   = 0;
  int b_chg  = 0;

  int nom_mv[12] = '{0, 110, 180, 260, 330, 410, 630, 710, 780, 860, 930, 1010};

  function automatic int thr_of(int i);
    return (nom_mv[i] + nom_mv[i+1]) * 2048 / 2400;
  endfunction

  function automatic int code_of(int m);
    return nom_mv[m] * 4096 / 2400;
  endfunction

  function automatic int decode(int code);
    int m = 0;
    for (int i = 0; i < 11; i++) if (code >= thr_of(i)) m = i + 1;
    return m;
  endfunction

  // behaviour letters: o off, n on, s slow, f fast; row = pattern (mode % 6), 4 statuses
  function automatic byte beh(int m, int st, bit red);
    string g_tab[6] = '{"onoo", "nooo", "osnf", "onof", "nsno", "oono"};
    string r_tab[6] = '{"ooof", "nooof", "oooo", "oooo", "nooof", "onof"};
    string s;
    s = red ? r_tab[m % 6] : g_tab[m % 6];
    if (red && (m % 6 == 1 || m % 6 == 4)) return s[st == 0 ? 0 : st + 1];
    return s[st];
  endfunction

  function automatic bit lit_of(byte b, int ph);
    case (b)
      "n": return 1'b1;
      "s": return (ph % CLK_HZ) < (CLK_HZ / 2);
      "f": return (ph % (CLK_HZ / 4)) < (CLK_HZ / 8);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] expect_at(int c);
    int ph;
    if (!b_lat) return 3'b110;
    ph = c - b_chg;
    return {!lit_of(beh(b_mode, b_st, 1'b0), ph), !lit_of(beh(b_mode, b_st, 1'b1), ph),
            (b_mode >= 6) ? 1'b1 : 1'b0};
  endfunction

  function automatic string pat_tag(int m);
    case (m % 6)
      0: return "R5 R3 R9";
      2: return "R6 R3 R9 R10";
      4: return "R7 R3 R9 R10";
      default: return "R8 R3 R9 R10";
    endcase
  endfunction

  task automatic tick(string tag);
    q_when.push_back(cyc + 1);
    q_val.push_back(expect_at(cyc + 1));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic set_status(int s);
    if (s != b_st) b_chg = cyc + 1;
    b_st = s;
    op_status = 2'(s);
  endtask

  task automatic strobe(int code, string tag);
    strap_code   = ADC_W'(code);
    strap_sample = 1'b1;
    if (!b_lat) begin
      b_lat  = 1;
      b_mode = decode(code);
    end
    tick(tag);
    strap_sample = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    strap_sample = 1'b0;
    op_status = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    b_lat = 0;
    b_st  = 0;
    b_chg = cyc;
  endtask

  task automatic run_case(int code, string dec_tag);
    int seq[6] = '{1, 2, 3, 1, 0, 2};
    do_reset();
    for (int k = 0; k < 3; k++) begin
      set_status(k);
      tick("R4 dark before capture");
    end
    set_status(0);
    tick("R4");
    strobe(code, dec_tag);
    for (int k = 0; k < 4; k++) tick(pat_tag(b_mode));
    strobe((code + 2048) % 4096, "R2 second sample ignored");
    foreach (seq[k]) begin
      set_status(seq[k]);
      for (int j = 0; j < 40; j++) tick({pat_tag(b_mode), " R11"});
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      while (q_when.size() > 0 && q_when[0] <= cyc) begin
        logic [2:0] e;
        logic [2:0] a;
        string      t;
        int         w;
        w = q_when.pop_front();
        e = q_val.pop_front();
        t = q_tag.pop_front();
        a = {led_grn_n, led_red_n, sense_hi_ohm};
        n_checks++;
        if (w != cyc || a !== e) begin
          n_fail++;
          $display("FAIL %s cyc=%0d {grn_n,red_n,sense} actual=%b expected=%b", t, cyc, a, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=finished", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: nominal level of every mode
    for (int m = 0; m < 12; m++) run_case(code_of(m), "R1 nominal decode");
    // R1: boundaries of the lowest threshold and the bank threshold (R3)
    run_case(0, "R1 zero code");
    run_case(thr_of(0) - 1, "R1 below first threshold");
    run_case(thr_of(0), "R1 at first threshold");
    run_case(thr_of(5) - 1, "R1 R3 below bank threshold");
    run_case(thr_of(5), "R1 R3 at bank threshold");
    run_case(4095, "R1 full scale");
    repeat (3) @(negedge clk);
    if (q_when.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard left=%0d expected=0", q_when.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule